// File: doc/BRIEF.md
# Pointer-Page Effective Address Generator

This block turns a decoded addressing format into a 32-bit effective address. It keeps eight 32-bit scratchpad pointer registers. Register 0 holds the base of the program's own 32-kilobyte page. Registers 1 to 7 each locate a table of 4096 word-sized address constants. The displacement of an instruction selects an entry in such a table. The own-page offset picks a byte inside the current page.

Two formats read memory once before they can finish. The post-indexed form reads a table entry and adds a byte index to the pointer it gets back. The indirect-jump form reads the word at its indexed address and uses that word as the target. Both use a single-outstanding read port with a request, an acknowledge and a data bus. The other formats finish in one cycle and do not touch memory. Each operation ends with a one-cycle `done_o` pulse, and `ea_o` carries the result.

Top module: `ptr_page_agu`

## Requirements
- R1: Scratchpad register n (0..7) takes the value of `sp_wdata_i` on a clock edge where `sp_we_i` is high and `sp_waddr_i` equals n. Operations started on later cycles use the new value.
- R2: Format code 0 (pointer-page), with pointer register p from 1 to 7, gives `ea_o` = sp[p] + 4*`disp_i`. `done_o` pulses in the cycle after the start, and no read is issued.
- R3: Format code 1 (post-indexed) issues one read at sp[p] + 4*`disp_i`. When the read completes, `ea_o` = returned word + `idx_i`, where `idx_i` is the value sampled at the start.
- R4: Format code 2 (indirect jump) issues one read at sp[p] + 4*`disp_i` + `idx_i`. The returned word itself becomes `ea_o`.
- R5: Format code 3 (own-page) gives `ea_o` = {sp[0][31:15], `off_i`} in one cycle with no read. The low 15 bits of sp[0] play no part.
- R6: Format code 4 (own-page indexed) gives `ea_o` = {sp[0][31:15], `off_i`} + `idx_i` in one cycle with no read. The carry may leave the page.
- R7: Format codes 0, 1 and 2 with pointer register 0 pulse `done_o` and `err_o` together in the cycle after the start. They issue no read and set `ea_o` to 0.
- R8: Format codes 5, 6 and 7 are reserved. They behave like R7: error with done, no read, `ea_o` = 0.
- R9: Every addition wraps modulo 2^32.
- R10: Once raised, `rd_req_o` stays high and `rd_addr_o` stays unchanged until `rd_ack_i` is sampled high. `rd_req_o` then drops, and `done_o` pulses in the next cycle.
- R11: A `start_i` that arrives while a read is outstanding is ignored. It causes no completion, no new read, and no change to the pending result.
- R12: After reset, `done_o`, `err_o` and `rd_req_o` are low, `ea_o` is 0, and all scratchpad registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sp_we_i | input | 1 | Scratchpad register write enable |
| sp_waddr_i | input | 3 | Scratchpad register to write |
| sp_wdata_i | input | 32 | Value written to the scratchpad register |
| start_i | input | 1 | Begin an address computation |
| fmt_i | input | 3 | Format code (0..4 defined, 5..7 reserved) |
| preg_i | input | 3 | Pointer register number |
| disp_i | input | 12 | Table displacement in 32-bit words |
| off_i | input | 15 | Byte offset inside the own page |
| idx_i | input | 32 | Index register value |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | 32 | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid with it |
| rd_data_i | input | 32 | Read data |
| ea_o | output | 32 | Effective address result |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, pulses with `done_o` |

## Verification
On every cycle, the assertions check the timing shape of each operation. They check that one-cycle formats finish in one cycle without a read, and that error cases flag together with done and never reach memory. They also check that a pending request holds its address, that an acknowledge leads to done one cycle later, and that nothing completes while a read is pending. Only the bench's scenarios can show the computed values. These include the displacement scaling, the concatenation that makes the own-page address, the post-indexed versus pre-indexed placement of the index, wraparound at 2^32, and that a start dropped during a fetch leaves the pending result untouched.

// File: rtl/ptr_page_agu_pkg.sv
package ptr_page_agu_pkg;
  localparam logic [2:0] FMT_PTR      = 3'd0;
  localparam logic [2:0] FMT_POST_IDX = 3'd1;
  localparam logic [2:0] FMT_JMP_IND  = 3'd2;
  localparam logic [2:0] FMT_OWN      = 3'd3;
  localparam logic [2:0] FMT_OWN_IDX  = 3'd4;

  typedef enum logic {ST_IDLE, ST_FETCH} agu_state_e;
endpackage

// File: rtl/ptr_page_spregs.sv
module ptr_page_spregs #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 8,
  parameter int unsigned OFFW = 15,
  localparam int unsigned RAW = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [RAW-1:0]     waddr_i,
  input  logic [AW-1:0]      wdata_i,
  input  logic [RAW-1:0]     raddr_i,
  output logic [AW-1:0]      rdata_o,
  output logic [AW-1:OFFW]   page_base_o
);
  logic [AW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[g] <= '0;
      else if (we_i && waddr_i == RAW'(g))    regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o     = regs_q[raddr_i];
  assign page_base_o = regs_q[0][AW-1:OFFW];
endmodule

// File: rtl/ptr_page_addr_calc.sv
module ptr_page_addr_calc
  import ptr_page_agu_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned RAW      = 3,
  parameter int unsigned DISPW    = 12,
  parameter int unsigned OFFW     = 15,
  parameter int unsigned SCALE_SH = 2
) (
  input  logic [2:0]       fmt_i,
  input  logic [RAW-1:0]   preg_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic [OFFW-1:0]  off_i,
  input  logic [AW-1:0]    idx_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [AW-1:OFFW] page_base_i,
  output logic             err_o,
  output logic             need_fetch_o,
  output logic [AW-1:0]    fetch_addr_o,
  output logic [AW-1:0]    direct_ea_o
);
  logic [AW-1:0] entry_addr;
  logic [AW-1:0] own_addr;
  logic          ptr_fmt;
  logic          reserved;

  // displacement counts words; scale to bytes, wrap at 2^AW
  assign entry_addr = ptr_i + (AW'(disp_i) << SCALE_SH);
  // own page: upper bits of reg 0 concatenated, no carry chain
  assign own_addr   = {page_base_i, off_i};

  assign ptr_fmt  = (fmt_i == FMT_PTR) || (fmt_i == FMT_POST_IDX) || (fmt_i == FMT_JMP_IND);
  assign reserved = (fmt_i > FMT_OWN_IDX);

  assign err_o        = reserved || (ptr_fmt && preg_i == '0);
  assign need_fetch_o = !err_o && ((fmt_i == FMT_POST_IDX) || (fmt_i == FMT_JMP_IND));
  assign fetch_addr_o = (fmt_i == FMT_JMP_IND) ? entry_addr + idx_i : entry_addr;

  always_comb begin
    unique case (fmt_i)
      FMT_PTR:     direct_ea_o = entry_addr;
      FMT_OWN:     direct_ea_o = own_addr;
      FMT_OWN_IDX: direct_ea_o = own_addr + idx_i;
      default:     direct_ea_o = '0;
    endcase
  end
endmodule

// File: rtl/ptr_page_fetch_ctl.sv
module ptr_page_fetch_ctl
  import ptr_page_agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    fmt_i,
  input  logic          err_i,
  input  logic          need_fetch_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic [AW-1:0] direct_ea_i,
  input  logic [AW-1:0] idx_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [AW-1:0] rd_data_i,
  output logic [AW-1:0] ea_o,
  output logic          done_o,
  output logic          err_o
);
  agu_state_e    state_q;
  logic [AW-1:0] post_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      post_idx_q <= '0;
      rd_req_o   <= 1'b0;
      rd_addr_o  <= '0;
      ea_o       <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (err_i) begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
              ea_o   <= '0;
            end else if (need_fetch_i) begin
              rd_req_o   <= 1'b1;
              rd_addr_o  <= fetch_addr_i;
              post_idx_q <= (fmt_i == FMT_POST_IDX) ? idx_i : '0;
              state_q    <= ST_FETCH;
            end else begin
              done_o <= 1'b1;
              ea_o   <= direct_ea_i;
            end
          end
        end
        ST_FETCH: begin
          // start_i is not looked at here: dropped while busy
          if (rd_ack_i) begin
            rd_req_o <= 1'b0;
            ea_o     <= rd_data_i + post_idx_q;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptr_page_agu.sv
module ptr_page_agu #(
  parameter int unsigned AW       = 32,
  parameter int unsigned NREG     = 8,
  parameter int unsigned DISPW    = 12,
  parameter int unsigned OFFW     = 15,
  parameter int unsigned SCALE_SH = 2,
  localparam int unsigned RAW     = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sp_we_i,
  input  logic [RAW-1:0]   sp_waddr_i,
  input  logic [AW-1:0]    sp_wdata_i,
  input  logic             start_i,
  input  logic [2:0]       fmt_i,
  input  logic [RAW-1:0]   preg_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic [OFFW-1:0]  off_i,
  input  logic [AW-1:0]    idx_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_ack_i,
  input  logic [AW-1:0]    rd_data_i,
  output logic [AW-1:0]    ea_o,
  output logic             done_o,
  output logic             err_o
);
  logic [AW-1:0]    ptr_val;
  logic [AW-1:OFFW] page_base;
  logic             calc_err;
  logic             need_fetch;
  logic [AW-1:0]    fetch_addr;
  logic [AW-1:0]    direct_ea;

  ptr_page_spregs #(.AW(AW), .NREG(NREG), .OFFW(OFFW)) u_spregs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sp_we_i),
    .waddr_i    (sp_waddr_i),
    .wdata_i    (sp_wdata_i),
    .raddr_i    (preg_i),
    .rdata_o    (ptr_val),
    .page_base_o(page_base)
  );

  ptr_page_addr_calc #(
    .AW(AW), .RAW(RAW), .DISPW(DISPW), .OFFW(OFFW), .SCALE_SH(SCALE_SH)
  ) u_calc (
    .fmt_i       (fmt_i),
    .preg_i      (preg_i),
    .disp_i      (disp_i),
    .off_i       (off_i),
    .idx_i       (idx_i),
    .ptr_i       (ptr_val),
    .page_base_i (page_base),
    .err_o       (calc_err),
    .need_fetch_o(need_fetch),
    .fetch_addr_o(fetch_addr),
    .direct_ea_o (direct_ea)
  );

  ptr_page_fetch_ctl #(.AW(AW)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .fmt_i       (fmt_i),
    .err_i       (calc_err),
    .need_fetch_i(need_fetch),
    .fetch_addr_i(fetch_addr),
    .direct_ea_i (direct_ea),
    .idx_i       (idx_i),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_ack_i    (rd_ack_i),
    .rd_data_i   (rd_data_i),
    .ea_o        (ea_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/ptr_page_agu_chk.sv
module ptr_page_agu_chk #(
  parameter int unsigned AW  = 32,
  parameter int unsigned RAW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [2:0]     fmt_i,
  input logic [RAW-1:0] preg_i,
  input logic           rd_req_o,
  input logic [AW-1:0]  rd_addr_o,
  input logic           rd_ack_i,
  input logic           done_o,
  input logic           err_o
);
  logic idle_start;
  assign idle_start = start_i && !rd_req_o;

  AST_PTR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && fmt_i == 3'd0 && preg_i != '0 |=> done_o && !err_o && !rd_req_o); // R2

  AST_FETCH_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && (fmt_i == 3'd1 || fmt_i == 3'd2) && preg_i != '0 |=> rd_req_o && !done_o); // R3

  AST_OWN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && (fmt_i == 3'd3 || fmt_i == 3'd4) |=> done_o && !err_o && !rd_req_o); // R5

  AST_REG0_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && fmt_i <= 3'd2 && preg_i == '0 |=> done_o && err_o && !rd_req_o); // R7

  AST_RESERVED_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_start && fmt_i > 3'd4 |=> done_o && err_o && !rd_req_o); // R8

  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R7

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R10

  AST_ACK_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> done_o && !err_o && !rd_req_o); // R10

  AST_BUSY_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> !done_o); // R11
endmodule

bind ptr_page_agu ptr_page_agu_chk #(.AW(AW), .RAW(RAW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .fmt_i    (fmt_i),
  .preg_i   (preg_i),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .rd_ack_i (rd_ack_i),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/ptr_page_agu_tb.sv
module ptr_page_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sp_we = 1'b0;
  logic [2:0]  sp_waddr = '0;
  logic [31:0] sp_wdata = '0;
  logic        start = 1'b0;
  logic [2:0]  fmt = '0;
  logic [2:0]  preg = '0;
  logic [11:0] disp = '0;
  logic [14:0] off = '0;
  logic [31:0] idx = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic [31:0] ea;
  logic        done;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ptr_page_agu u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sp_we_i(sp_we), .sp_waddr_i(sp_waddr), .sp_wdata_i(sp_wdata),
    .start_i(start), .fmt_i(fmt), .preg_i(preg), .disp_i(disp),
    .off_i(off), .idx_i(idx),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .ea_o(ea), .done_o(done), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_sp(input logic [2:0] n, input logic [31:0] v);
    @(negedge clk);
    sp_we = 1'b1; sp_waddr = n; sp_wdata = v;
    @(negedge clk);
    sp_we = 1'b0;
  endtask

  // one-cycle operation; result visible one edge after start
  task automatic run_direct(input string req, input logic [2:0] f, input logic [2:0] p,
                            input logic [11:0] d, input logic [14:0] o, input logic [31:0] x,
                            input logic [31:0] exp_ea, input logic exp_err);
    @(negedge clk);
    start = 1'b1; fmt = f; preg = p; disp = d; off = o; idx = x;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, 32'(done), 32'd1);
    chk({req, " err"}, 32'(err), 32'(exp_err));
    chk({req, " no read"}, 32'(rd_req), 32'd0);
    chk({req, " ea"}, ea, exp_ea);
    @(negedge clk);
    chk({req, " done pulse"}, 32'(done), 32'd0);
  endtask

  task automatic run_fetch(input string req, input logic [2:0] f, input logic [2:0] p,
                           input logic [11:0] d, input logic [31:0] x,
                           input logic [31:0] exp_addr, input int wait_n,
                           input logic [31:0] data, input logic [31:0] exp_ea);
    @(negedge clk);
    start = 1'b1; fmt = f; preg = p; disp = d; idx = x;
    @(negedge clk);
    start = 1'b0;
    idx = 32'h5555_5555; // index must have been sampled at start
    chk({req, " req raised"}, 32'(rd_req), 32'd1);
    chk({req, " read addr"}, rd_addr, exp_addr);
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk({req, " R10 req held"}, 32'(rd_req), 32'd1);
      chk({req, " R10 addr held"}, rd_addr, exp_addr);
      chk({req, " R10 no early done"}, 32'(done), 32'd0);
    end
    rd_ack = 1'b1; rd_data = data;
    @(negedge clk);
    rd_ack = 1'b0; rd_data = 32'hBAD0_BAD0;
    chk({req, " R10 req dropped"}, 32'(rd_req), 32'd0);
    chk({req, " R10 done"}, 32'(done), 32'd1);
    chk({req, " err"}, 32'(err), 32'd0);
    chk({req, " ea"}, ea, exp_ea);
  endtask

  task automatic t_reset;
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 err", 32'(err), 32'd0);
    chk("R12 req", 32'(rd_req), 32'd0);
    chk("R12 ea", ea, 32'd0);
    run_direct("R12 sp0 zero", 3'd3, 3'd0, 12'd0, 15'h1234, 32'd0, 32'h0000_1234, 1'b0);
    run_direct("R12 sp4 zero", 3'd0, 3'd4, 12'd3, 15'd0, 32'd0, 32'h0000_000C, 1'b0);
  endtask

  task automatic t_ptr_page;
    wr_sp(3'd3, 32'h1000_0000);
    run_direct("R2 R1 ptr page", 3'd0, 3'd3, 12'h123, 15'h7FFF, 32'hFFFF_FFFF, 32'h1000_048C, 1'b0);
    wr_sp(3'd7, 32'hFFFF_FFF0);
    run_direct("R9 ptr wrap", 3'd0, 3'd7, 12'hFFF, 15'd0, 32'd0, 32'h0000_3FEC, 1'b0);
  endtask

  task automatic t_post_idx;
    wr_sp(3'd2, 32'h2000_0000);
    run_fetch("R3 post idx", 3'd1, 3'd2, 12'd5, 32'h0000_0044, 32'h2000_0014, 3,
              32'h8000_0100, 32'h8000_0144);
    run_fetch("R9 post idx wrap", 3'd1, 3'd2, 12'd0, 32'h0000_0002, 32'h2000_0000, 0,
              32'hFFFF_FFFF, 32'h0000_0001);
  endtask

  task automatic t_jump;
    wr_sp(3'd5, 32'h3000_0000);
    run_fetch("R4 jump ind", 3'd2, 3'd5, 12'd2, 32'h0000_0010, 32'h3000_0018, 0,
              32'hDEAD_BEE0, 32'hDEAD_BEE0);
  endtask

  task automatic t_own;
    wr_sp(3'd0, 32'h1234_5678);
    run_direct("R5 own hi off", 3'd3, 3'd1, 12'hFFF, 15'h7FFF, 32'h100, 32'h1234_7FFF, 1'b0);
    run_direct("R5 own low bits ignored", 3'd3, 3'd0, 12'd0, 15'h0001, 32'd0, 32'h1234_0001, 1'b0);
    run_direct("R6 own idx cross page", 3'd4, 3'd0, 12'd0, 15'h7FF0, 32'h20, 32'h1234_8010, 1'b0);
    wr_sp(3'd0, 32'hFFFF_8000);
    run_direct("R9 R6 own idx wrap", 3'd4, 3'd0, 12'd0, 15'h7FFF, 32'd1, 32'h0000_0000, 1'b0);
  endtask

  task automatic t_errors;
    run_direct("R7 fmt0 reg0", 3'd0, 3'd0, 12'd1, 15'd0, 32'd0, 32'd0, 1'b1);
    run_direct("R7 fmt1 reg0", 3'd1, 3'd0, 12'd1, 15'd0, 32'd0, 32'd0, 1'b1);
    run_direct("R7 fmt2 reg0", 3'd2, 3'd0, 12'd1, 15'd0, 32'd0, 32'd0, 1'b1);
    for (int f = 5; f < 8; f++)
      run_direct("R8 reserved", 3'(f), 3'd3, 12'd1, 15'd1, 32'd1, 32'd0, 1'b1);
  endtask

  task automatic t_busy;
    wr_sp(3'd6, 32'h4000_0000);
    @(negedge clk);
    start = 1'b1; fmt = 3'd1; preg = 3'd6; disp = 12'd1; idx = 32'h8;
    @(negedge clk);
    // second start while fetch pending: own-page, would finish at once
    fmt = 3'd3; preg = 3'd0; off = 15'h0ABC; idx = 32'h0;
    chk("R11 req", 32'(rd_req), 32'd1);
    @(negedge clk);
    start = 1'b0;
    chk("R11 no done", 32'(done), 32'd0);
    chk("R11 addr kept", rd_addr, 32'h4000_0004);
    chk("R11 req kept", 32'(rd_req), 32'd1);
    rd_ack = 1'b1; rd_data = 32'h0000_1000;
    @(negedge clk);
    rd_ack = 1'b0;
    chk("R11 done", 32'(done), 32'd1);
    chk("R11 result", ea, 32'h0000_1008);
    @(negedge clk);
    chk("R11 no late done", 32'(done), 32'd0);
    chk("R11 no new read", 32'(rd_req), 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr_page();
    t_post_idx();
    t_jump();
    t_own();
    t_errors();
    t_busy();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule